// File: doc/BRIEF.md
# SEC-DED Protected Instruction Fetch

This block takes protected code words from an external code memory and hands clean compact instructions to a small processor core. Each stored word is 16 bits: 11 instruction bits guarded by a Hamming code with five check bits. Any single flipped bit, such as one caused by a particle strike, is repaired without the core noticing. A word with two flipped bits is dropped, and a sticky flag reports it.

The memory side runs in one of two modes. In word mode one 16-bit read delivers the whole code word. In byte mode two 8-bit reads deliver it: the low byte comes from the even address and the high byte from the following odd address. The two halves are joined before the check is run. The core side uses a valid/ready handshake and stalls cleanly. A package function builds code words for test images.

Top module: `ecc_fetch_unit`

## Requirements
- R1: Code word layout. Bits 14:0 hold a Hamming(15,11) code in which bit index i is position i+1. Check bits sit at positions 1, 2, 4 and 8. Payload bit 0 goes to the lowest remaining position and the higher payload bits fill the remaining positions upward. Bit 15 makes the parity of the whole 16-bit word even. The package encoder builds exactly this layout.
- R2: A code word with no error is delivered with its payload unchanged, and `corr_pulse` stays low.
- R3: A word with exactly one flipped bit, in any of the 16 positions including bit 15, is delivered with the original payload. `corr_pulse` is high in the first cycle in which that word is presented, and only while `out_vld` is high.
- R4: A word with two flipped bits is never presented: `out_vld` stays low. `uncorr_err` rises one cycle after the word completes and stays high until reset.
- R5: In word mode (`byte_mode`=0), a word accepted at a clock edge shows on `out_vld`/`out_insn` right after that same edge. This is one cycle of latency.
- R6: In byte mode (`byte_mode`=1), `mem_half`=0 asks for the low byte (address 2n) and `mem_half`=1 asks for the high byte (address 2n+1). Both bytes come in on `mem_data[7:0]`. Nothing is presented after the low byte alone. The word shows right after the edge that accepts the high byte.
- R7: While `out_vld` is high and `out_rdy` is low, `out_vld` and `out_insn` hold their values and `mem_rdy` is low. When `out_rdy` returns high, a new word can be accepted in the same cycle.
- R8: After reset, `out_vld`, `corr_pulse`, `uncorr_err` and `mem_half` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = two 8-bit reads per word, 0 = one 16-bit read |
| mem_vld | input | 1 | Memory data valid |
| mem_data | input | 16 | Memory read data; in byte mode only bits 7:0 are used |
| mem_rdy | output | 1 | Block accepts memory data this cycle |
| mem_half | output | 1 | Byte mode: 0 = low byte expected, 1 = high byte expected |
| out_vld | output | 1 | Instruction valid toward the core |
| out_rdy | input | 1 | Core accepts the instruction |
| out_insn | output | 11 | Corrected compact instruction |
| corr_pulse | output | 1 | A single-bit error was corrected in the presented word |
| uncorr_err | output | 1 | Sticky flag for a double-bit error |

## Verification
Some properties are checked by assertions on every cycle:
- the output holds while the core stalls;
- `corr_pulse` never appears without valid data;
- the uncorrectable flag, once set, stays set, and rises after a double error completes;
- in byte mode the high byte always follows the low byte.

Other behaviour only the bench's scenarios can show. These are the payload values recovered from each of the 16 single flips in both fetch modes, the exact output cycle in each mode, the encoder layout, and the handling of a sample of double flips.

// File: rtl/ecc_fetch_pkg.sv
package ecc_fetch_pkg;
  localparam int unsigned CW_W  = 16;
  localparam int unsigned HAM_W = CW_W - 1;
  localparam int unsigned SYN_W = 4;
  localparam int unsigned PL_W  = HAM_W - SYN_W;

  // syndrome: XOR of the 1-based positions of all set bits
  function automatic logic [SYN_W-1:0] ham_syndrome(input logic [HAM_W-1:0] w);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int i = 0; i < HAM_W; i++)
      if (w[i]) s = s ^ SYN_W'(i + 1);
    return s;
  endfunction

  function automatic logic is_check_pos(input int unsigned pos);
    return ((pos & (pos - 1)) == 0);
  endfunction

  function automatic logic [HAM_W-1:0] scatter_payload(input logic [PL_W-1:0] p);
    logic [HAM_W-1:0] h;
    int unsigned k;
    h = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= HAM_W; pos++)
      if (!is_check_pos(pos)) begin
        h[pos-1] = p[k];
        k++;
      end
    return h;
  endfunction

  function automatic logic [PL_W-1:0] gather_payload(input logic [HAM_W-1:0] h);
    logic [PL_W-1:0] p;
    int unsigned k;
    p = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= HAM_W; pos++)
      if (!is_check_pos(pos)) begin
        p[k] = h[pos-1];
        k++;
      end
    return p;
  endfunction

  // encoder for test images: syndrome of data-only word becomes the check bits
  function automatic logic [CW_W-1:0] ecc_encode(input logic [PL_W-1:0] p);
    logic [HAM_W-1:0] h;
    logic [SYN_W-1:0] s;
    h = scatter_payload(p);
    s = ham_syndrome(h);
    for (int b = 0; b < SYN_W; b++) h[(1 << b) - 1] = s[b];
    return {^h, h};
  endfunction
endpackage

// File: rtl/byte_assembler.sv
module byte_assembler #(
  parameter int unsigned CW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_mode,
  input  logic            beat,
  input  logic [CW_W-1:0] data,
  output logic            half,
  output logic            last_beat,
  output logic [CW_W-1:0] word
);
  localparam int unsigned BYTE_W = CW_W / 2;

  logic              half_q, half_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              lo_en;

  always_comb begin
    half_d = half_q;
    if (!byte_mode)  half_d = 1'b0;
    else if (beat)   half_d = ~half_q;
    lo_en = beat && byte_mode && !half_q;
    lo_d  = data[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign half      = half_q;
  assign last_beat = !byte_mode || half_q;
  assign word      = byte_mode ? {data[BYTE_W-1:0], lo_q} : data;

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && byte_mode && !half_q && byte_mode) |=> (half_q || !byte_mode)); // R6
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import ecc_fetch_pkg::*;
(
  input  logic [CW_W-1:0] cw,
  output logic [PL_W-1:0] payload,
  output logic            single_err,
  output logic            double_err
);
  logic [SYN_W-1:0] syn;
  logic             par_bad;
  logic [HAM_W-1:0] flip;
  logic [HAM_W-1:0] fixed;

  always_comb begin
    syn     = ham_syndrome(cw[HAM_W-1:0]);
    par_bad = ^cw;
    flip    = '0;
    if (par_bad && (syn != '0)) flip = HAM_W'(1) << (syn - SYN_W'(1));
    fixed      = cw[HAM_W-1:0] ^ flip;
    payload    = gather_payload(fixed);
    single_err = par_bad;
    double_err = !par_bad && (syn != '0);
  end
endmodule

// File: rtl/fetch_out_stage.sv
module fetch_out_stage #(
  parameter int unsigned PL_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PL_W-1:0] payload,
  input  logic            single_err,
  input  logic            double_err,
  input  logic            out_rdy,
  output logic            out_vld,
  output logic [PL_W-1:0] out_insn,
  output logic            corr_pulse,
  output logic            uncorr_err
);
  logic            vld_q, vld_d;
  logic [PL_W-1:0] ins_q, ins_d;
  logic            ins_en;
  logic            corr_q, corr_d;
  logic            unc_q, unc_d;

  always_comb begin
    vld_d = vld_q;
    if (out_rdy) vld_d = 1'b0;
    if (load)    vld_d = !double_err;
    ins_en = load && !double_err;
    ins_d  = payload;
    corr_d = load && !double_err && single_err;
    unc_d  = unc_q || (load && double_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      corr_q <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ins_q <= '0;
    else if (ins_en) ins_q <= ins_d;
  end

  assign out_vld    = vld_q;
  assign out_insn   = ins_q;
  assign corr_pulse = corr_q;
  assign uncorr_err = unc_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_rdy) |=> (vld_q && $stable(ins_q))); // R7
  AST_CORR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    corr_q |-> vld_q); // R3
  AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unc_q |=> unc_q); // R4
  AST_DOUBLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && double_err) |=> (unc_q && !corr_q)); // R4
endmodule

// File: rtl/ecc_fetch_unit.sv
module ecc_fetch_unit
  import ecc_fetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_mode,
  input  logic            mem_vld,
  input  logic [CW_W-1:0] mem_data,
  output logic            mem_rdy,
  output logic            mem_half,
  output logic            out_vld,
  input  logic            out_rdy,
  output logic [PL_W-1:0] out_insn,
  output logic            corr_pulse,
  output logic            uncorr_err
);
  logic            beat;
  logic            last_beat;
  logic [CW_W-1:0] word;
  logic [PL_W-1:0] dec_payload;
  logic            dec_single;
  logic            dec_double;

  assign mem_rdy = !out_vld || out_rdy;
  assign beat    = mem_vld && mem_rdy;

  byte_assembler #(.CW_W(CW_W)) i_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .beat      (beat),
    .data      (mem_data),
    .half      (mem_half),
    .last_beat (last_beat),
    .word      (word)
  );

  secded_decoder i_dec (
    .cw         (word),
    .payload    (dec_payload),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  fetch_out_stage #(.PL_W(PL_W)) i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (beat && last_beat),
    .payload    (dec_payload),
    .single_err (dec_single),
    .double_err (dec_double),
    .out_rdy    (out_rdy),
    .out_vld    (out_vld),
    .out_insn   (out_insn),
    .corr_pulse (corr_pulse),
    .uncorr_err (uncorr_err)
  );
endmodule

// File: tb/test_ecc_fetch_unit.sv
module test_ecc_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;
  localparam int NVEC       = 12;
  // {payload[10:0], flip mask[15:0], kind[1:0]} kind: 0 clean, 1 single, 2 double
  localparam logic [28:0] VEC [NVEC] = '{
    {11'h000, 16'h0000, 2'd0}, {11'h7FF, 16'h0000, 2'd0},
    {11'h555, 16'h0000, 2'd0}, {11'h2AA, 16'h0001, 2'd1},
    {11'h123, 16'h8000, 2'd1}, {11'h456, 16'h0400, 2'd1},
    {11'h7FF, 16'h4000, 2'd1}, {11'h001, 16'h0080, 2'd1},
    {11'h3C3, 16'h0000, 2'd0}, {11'h0F0, 16'h0003, 2'd2},
    {11'h6A5, 16'h8001, 2'd2}, {11'h1E7, 16'h0240, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_mode;
  logic        mem_vld;
  logic [15:0] mem_data;
  logic        mem_rdy, mem_half, out_vld, out_rdy, corr_pulse, uncorr_err;
  logic [10:0] out_insn;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fetch_unit i_ecc_fetch_unit (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .mem_vld(mem_vld),
    .mem_data(mem_data), .mem_rdy(mem_rdy), .mem_half(mem_half),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_insn(out_insn),
    .corr_pulse(corr_pulse), .uncorr_err(uncorr_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // independent encoder: parity k covers every position with bit k set
  function automatic logic [15:0] tb_enc(input logic [10:0] p);
    logic [15:0] w;
    int j;
    w = '0;
    j = 0;
    for (int pos = 1; pos <= 15; pos++)
      if (pos != 1 && pos != 2 && pos != 4 && pos != 8) begin
        w[pos-1] = p[j];
        j++;
      end
    for (int k = 0; k < 4; k++) begin
      logic par;
      par = 1'b0;
      for (int pos = 1; pos <= 15; pos++)
        if (((pos >> k) & 1) == 1) par = par ^ w[pos-1];
      w[(1 << k) - 1] = par;
    end
    w[15] = ^w[14:0];
    return w;
  endfunction

  // deliver one code word; returns after the completing edge + 1
  task automatic send(input logic [15:0] cw, input logic bmode);
    @(negedge clk);
    byte_mode = bmode;
    mem_vld   = 1'b1;
    if (bmode) begin
      chk(mem_half == 1'b0, "R6", "low byte first", mem_half, 0);
      mem_data = {8'h00, cw[7:0]};
      @(posedge clk); #1;
      chk(out_vld == 1'b0, "R6", "no output after low byte", out_vld, 0);
      chk(mem_half == 1'b1, "R6", "high byte next", mem_half, 1);
      @(negedge clk);
      mem_data = {8'hA5, cw[15:8]};
    end else begin
      mem_data = cw;
    end
    @(posedge clk); #1;
  endtask

  task automatic idle;
    @(negedge clk);
    mem_vld = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic run_case(input logic [10:0] pl, input logic [15:0] flip,
                          input int kind, input logic bmode);
    send(tb_enc(pl) ^ flip, bmode);
    if (kind == 2) begin
      chk(out_vld == 1'b0, "R4", "double not presented", out_vld, 0);
      chk(uncorr_err == 1'b1, "R4", "uncorr set", uncorr_err, 1);
    end else begin
      chk(out_vld == 1'b1, bmode ? "R6" : "R5", "latency one", out_vld, 1);
      chk(out_insn == pl, kind == 1 ? "R3" : "R2", "payload", out_insn, pl);
      chk(corr_pulse == (kind == 1), kind == 1 ? "R3" : "R2", "corr pulse",
          corr_pulse, kind == 1);
    end
    idle();
    chk(corr_pulse == 1'b0, "R3", "pulse one cycle", corr_pulse, 0);
  endtask

  initial begin
    rst_n = 1'b0; byte_mode = 1'b0; mem_vld = 1'b0; mem_data = '0; out_rdy = 1'b1;
    #(3*CLK_PERIOD);
    chk(out_vld == 0 && corr_pulse == 0 && uncorr_err == 0 && mem_half == 0,
        "R8", "reset state", {out_vld, corr_pulse, uncorr_err, mem_half}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: package encoder matches the stated layout
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] p;
      p = VEC[v][28:18];
      chk(ecc_fetch_pkg::ecc_encode(p) == tb_enc(p), "R1", "encoder layout",
          ecc_fetch_pkg::ecc_encode(p), tb_enc(p));
    end

    // clean and single-flip cases from the table, both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < NVEC; v++)
        if (VEC[v][1:0] != 2'd2)
          run_case(VEC[v][28:18], VEC[v][17:2], int'(VEC[v][1:0]), m[0]);

    // every single flip on several payloads, both modes
    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 3; q++)
        for (int b = 0; b < 16; b++)
          run_case(11'(q * 11'h2D3 + 11'h05A), 16'(1) << b, 1, m[0]);

    // R7: stall holds output and blocks memory
    @(negedge clk); out_rdy = 1'b0;
    send(tb_enc(11'h321), 1'b0);
    chk(out_vld == 1'b1 && out_insn == 11'h321, "R7", "first word", out_insn, 11'h321);
    @(negedge clk); mem_data = tb_enc(11'h654);
    chk(mem_rdy == 1'b0, "R7", "mem_rdy low in stall", mem_rdy, 0);
    @(posedge clk); #1;
    chk(out_vld == 1'b1 && out_insn == 11'h321, "R7", "held in stall", out_insn, 11'h321);
    @(negedge clk); out_rdy = 1'b1;
    @(posedge clk); #1;
    chk(out_vld == 1'b1 && out_insn == 11'h654, "R7", "accept on release", out_insn, 11'h654);
    idle();
    chk(out_vld == 1'b0, "R7", "drained", out_vld, 0);

    // double flips from the table, both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < NVEC; v++)
        if (VEC[v][1:0] == 2'd2)
          run_case(VEC[v][28:18], VEC[v][17:2], 2, m[0]);
    run_case(11'h0AB, 16'h0000, 0, 1'b0);
    chk(uncorr_err == 1'b1, "R4", "sticky after clean word", uncorr_err, 1);

    // reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(uncorr_err == 1'b0 && out_vld == 1'b0, "R8", "reset clears flags",
        {uncorr_err, out_vld}, 0);
    @(negedge clk); rst_n = 1'b1;
    run_case(11'h7A1, 16'h0010, 1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule